// File: doc/BRIEF.md
# Frame Controller Control, Status and Vertical-Sync Interrupt

This block is the small register bank that sits beside a framebuffer controller. It holds one control byte, a status byte that reports a fixed board identification together with a live interrupt-pending flag, and fourteen plain storage bytes. Those storage bytes hold cursor and video-control settings that other logic reads. The register bus is byte-wide and byte-addressed over a 32-byte window. Reads are combinational: `bus_rdata` always shows the register that `bus_addr` selects. Writes take effect at the rising clock edge when `bus_sel` and `bus_wr` are both high.

The display pipeline pulses `frame_end` for one cycle at the end of every displayed frame. If the interrupt-enable bit in the control byte is set, that pulse latches the pending flag. The interrupt output `vsync_irq` is a level signal that follows the flag. Software acknowledges the interrupt by writing the status byte with any value. If a frame-end pulse and an acknowledge arrive in the same cycle, the frame-end pulse takes priority, so no frame interrupt is lost.

Top module: `frame_ctl_status`

## Requirements
- R1: After reset, `vsync_irq` is low, the control byte and all storage bytes read 0x00, and the status byte reads 0x61.
- R2: Offset 0x10 is the control byte. It is read/write and is written only when `bus_sel` and `bus_wr` are both high. Its bit 7 enables the interrupt.
- R3: A `frame_end` pulse while control bit 7 is 1 sets the pending flag at that clock edge. `vsync_irq` is high from the following cycle, and `vsync_irq` always equals the pending flag.
- R4: A `frame_end` pulse while control bit 7 is 0 leaves the pending flag unchanged. Clearing bit 7 while the flag is set does not clear the flag.
- R5: A write to offset 0x11, with any data, clears the pending flag and lowers `vsync_irq` from the next cycle. A cycle at offset 0x11 with `bus_sel` low, or with `bus_wr` low, does not clear the flag.
- R6: A read of offset 0x11 returns the pending flag in bit 7 and the constant 0x61 in bits 6..0. Write data never changes bits 6..0.
- R7: Offsets 0x12 through 0x1F are independent read/write bytes. Each one keeps its last written value.
- R8: Reads of offsets 0x00 through 0x0F return 0x00. Writes to those offsets change no register.
- R9: When `frame_end` (with bit 7 set) and a status write fall in the same cycle, the pending flag ends up set.
- R10: When a control write and `frame_end` fall in the same cycle, the enable value from before the write decides whether the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe; when low with `bus_sel` high, the cycle is a read |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| vsync_irq | output | 1 | Level interrupt, high while the flag is pending |

## Verification
Two events can land on the pending flag in the same cycle: the frame-end pulse and a software acknowledge (a status write). A control write can also coincide with the frame-end pulse. The bench drives these pairs in the same cycle, both with the flag already set and with it clear, and with the enable bit switching in that cycle. A behavioural model applies the stated priority and enable timing, and the bench compares `vsync_irq` and the status read against the model after every clock.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] ofs_t;

  localparam ofs_t OFS_CTRL     = 5'h10;
  localparam ofs_t OFS_STAT     = 5'h11;
  localparam ofs_t OFS_GP_FIRST = 5'h12;
  localparam ofs_t OFS_GP_LAST  = 5'h1F;
  localparam int   GP_COUNT     = int'(OFS_GP_LAST) - int'(OFS_GP_FIRST) + 1;

  localparam int    EN_BIT   = 7;
  localparam int    PEND_BIT = 7;
  localparam byte_t STAT_ID  = 8'h61;

  // Status view: fixed identification with the pending flag merged in.
  function automatic byte_t status_view(input logic pend);
    byte_t v;
    v = STAT_ID;
    v[PEND_BIT] = pend;
    return v;
  endfunction

  // Offsets below the control byte are unimplemented.
  function automatic logic is_low_ofs(input ofs_t a);
    return int'(a) < int'(OFS_CTRL);
  endfunction

  function automatic ofs_t gp_ofs(input int k);
    return ofs_t'(int'(OFS_GP_FIRST) + k);
  endfunction
endpackage

// File: rtl/fcs_byte_reg.sv
module fcs_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/fcs_vsync_irq.sv
module fcs_vsync_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic irq_en,
  input  logic ack,
  output logic pending
);
  logic raise_ev;
  assign raise_ev = frame_end & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (raise_ev) pending <= 1'b1;
    else if (ack)      pending <= 1'b0;
  end

  // R3
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && irq_en) |=> pending);
  // R5
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !frame_end) |=> !pending);
  // R4
  no_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !ack) |=> $stable(pending));
  // R9
  race_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && irq_en && ack) |=> pending);
endmodule

// File: rtl/frame_ctl_status.sv
module frame_ctl_status
  import fcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       frame_end,
  output logic       vsync_irq
);
  logic  wr_cyc, ctrl_wr, stat_wr;
  byte_t ctrl_q;
  byte_t gp_q [GP_COUNT];
  logic  pending;

  assign wr_cyc  = bus_sel & bus_wr;
  assign ctrl_wr = wr_cyc && (bus_addr == OFS_CTRL);
  assign stat_wr = wr_cyc && (bus_addr == OFS_STAT);

  fcs_byte_reg #(.W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_wr), .d(bus_wdata), .q(ctrl_q)
  );

  for (genvar k = 0; k < GP_COUNT; k++) begin : g_gp
    logic gp_wr;
    assign gp_wr = wr_cyc && (bus_addr == gp_ofs(k));
    fcs_byte_reg #(.W(BYTE_W)) u_gp (
      .clk(clk), .rst_n(rst_n), .we(gp_wr), .d(bus_wdata), .q(gp_q[k])
    );
  end

  fcs_vsync_irq u_irq (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
    .irq_en(ctrl_q[EN_BIT]), .ack(stat_wr), .pending(pending)
  );

  assign vsync_irq = pending;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CTRL)      bus_rdata = ctrl_q;
    else if (bus_addr == OFS_STAT) bus_rdata = status_view(pending);
    else begin
      for (int k = 0; k < GP_COUNT; k++)
        if (bus_addr == gp_ofs(k)) bus_rdata = gp_q[k];
    end
  end

  // R6
  stat_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_STAT) |-> (bus_rdata[7] == vsync_irq && bus_rdata[6:0] == 7'h61));
  // R8
  low_ofs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_low_ofs(bus_addr) |-> (bus_rdata == 8'h00));
  // R10
  old_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && ctrl_wr && !ctrl_q[7] && !vsync_irq) |=> !vsync_irq);
endmodule

// File: tb/test_frame_ctl_status.sv
module test_frame_ctl_status;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, frame_end = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       vsync_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  int m_reg [32];
  bit m_pend;

  frame_ctl_status i_frame_ctl_status (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_end(frame_end), .vsync_irq(vsync_irq)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int exp_read(input int a);
    if (a == 16) return m_reg[16];
    if (a == 17) return 'h61 | (m_pend ? 'h80 : 0);
    if (a >= 18) return m_reg[a];
    return 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock of stimulus, model update at the edge, compare irq afterwards
  task automatic step(input bit s, input bit w, input int a, input int d,
                      input bit fe, input string req);
    bit np;
    bus_sel = s; bus_wr = w; bus_addr = 5'(a); bus_wdata = 8'(d); frame_end = fe;
    @(posedge clk);
    np = m_pend;
    if (fe && m_reg[16][7]) np = 1;
    else if (s && w && a == 17) np = 0;
    if (s && w && a == 16) m_reg[16] = d & 'hff;
    if (s && w && a >= 18) m_reg[a] = d & 'hff;
    m_pend = np;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; frame_end = 0;
    check(req, int'(vsync_irq), int'(m_pend));
  endtask

  task automatic rd(input int a, input string req);
    bus_sel = 1; bus_wr = 0; bus_addr = 5'(a);
    #1;
    check(req, int'(bus_rdata), exp_read(a));
    bus_sel = 0;
  endtask

  task automatic wr(input int a, input int d, input string req);
    step(1, 1, a, d, 0, req);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (m_reg[i]) m_reg[i] = 0;
    m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(vsync_irq), 0);
    for (int a = 0; a < 32; a++) rd(a, "R1");

    // R2 control read/write and qualification
    wr(16, 'h5A, "R2"); rd(16, "R2");
    step(1, 0, 16, 'hFF, 0, "R2"); rd(16, "R2");
    step(0, 1, 16, 'hFF, 0, "R2"); rd(16, "R2");
    wr(16, 'h80, "R2"); rd(16, "R2");

    // R3 enabled frame end raises the interrupt
    step(0, 0, 0, 0, 1, "R3"); rd(17, "R6");
    step(0, 0, 0, 0, 1, "R3"); rd(17, "R3");

    // R5 acknowledge with various data; unqualified cycles do not clear
    step(0, 1, 17, 'h00, 0, "R5"); step(1, 0, 17, 'h00, 0, "R5");
    wr(17, 'h00, "R5"); rd(17, "R6");
    step(0, 0, 0, 0, 1, "R3");
    wr(17, 'hFF, "R5"); rd(17, "R6");
    wr(17, 'h1E, "R6"); rd(17, "R6");

    // R4 disabled frame end; clearing enable keeps a pending flag
    wr(16, 'h7F, "R4"); step(0, 0, 0, 0, 1, "R4"); rd(17, "R4");
    wr(16, 'h80, "R4"); step(0, 0, 0, 0, 1, "R4");
    wr(16, 'h00, "R4"); rd(17, "R4");
    repeat (3) step(0, 0, 0, 0, 1, "R4");
    wr(17, 'h55, "R5");

    // R7 storage bytes
    for (int a = 18; a < 32; a++) wr(a, (a * 37 + 11) & 'hff, "R7");
    for (int a = 18; a < 32; a++) rd(a, "R7");
    wr(20, 'hA5, "R7"); for (int a = 18; a < 32; a++) rd(a, "R7");

    // R8 low offsets: writes ignored, reads zero
    for (int a = 0; a < 16; a++) wr(a, 'hFF, "R8");
    for (int a = 0; a < 32; a++) rd(a, "R8");

    // R9 frame end and acknowledge in the same cycle
    wr(16, 'h80, "R9");
    step(1, 1, 17, 'h00, 1, "R9"); rd(17, "R9");
    step(1, 1, 17, 'hAA, 1, "R9"); rd(17, "R9");
    wr(17, 0, "R9");

    // R10 control write coinciding with frame end uses the old enable
    wr(16, 'h00, "R10");
    step(1, 1, 16, 'h80, 1, "R10"); rd(17, "R10");
    step(1, 1, 16, 'h00, 1, "R10"); rd(17, "R10");
    rd(16, "R10");
    step(1, 1, 16, 'h00, 1, "R10"); rd(17, "R10");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule